// File: doc/BRIEF.md
# MII Receive Frame Deserializer

This block sits on the receive side of a 4-bit media-independent interface and runs on the receive clock that the PHY supplies. It hunts for a full preamble and start-frame delimiter. Once it has found them, it pairs the data nibbles that follow into bytes and writes each byte through a simple write port into a byte-wide frame buffer.

When data valid drops, the block publishes the number of bytes stored, together with an error flag and an odd-nibble flag. These results stay frozen until the consumer has drained the buffer and pulses a done input. Any frame that starts while a result is still pending is dropped whole.

Top module: `mii_rx_deframer`

## Requirements
- R1: After reset, `rx_size` is 0, `rx_bad` and `rx_odd` are 0, and `wr_en` is 0.
- R2: A frame is accepted only if it begins with at least 15 consecutive nibbles of 0x5 and the next nibble is 0xD. If any other nibble appears first, the frame produces no writes and leaves `rx_size` unchanged until data valid drops.
- R3: Data nibbles after the delimiter are paired low nibble first, so the first nibble becomes bits 3:0 of a byte. Each byte causes a one-cycle `wr_en` pulse, and `wr_addr` starts at 0 for every frame and goes up by 1 per byte.
- R4: On the receive clock edge that samples data valid low after data, `rx_size` takes the number of bytes written.
- R5: If `rx_er` is sampled high on any edge where data valid is high, from the first preamble nibble to the last data nibble, `rx_bad` is set for that frame.
- R6: If the frame ends after an odd number of data nibbles, `rx_odd` is set and the unpaired nibble is never written.
- R7: A frame whose data valid drops before the delimiter, or one that ends with no complete byte, is discarded with no writes and no change to `rx_size`.
- R8: While `rx_size` is nonzero, any new frame is ignored and produces no writes.
- R9: A `rd_done` pulse while `rx_size` is nonzero clears `rx_size`, `rx_bad` and `rx_odd` on the next edge. `rd_done` has no effect when nothing is pending, including during reception.
- R10: Bytes beyond the buffer capacity of 2^ADDR_W are not written, `rx_size` saturates at that capacity, and `rx_bad` is set.
- R11: While a result is pending and `rd_done` is low, `rx_size`, `rx_bad` and `rx_odd` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock from the PHY |
| rst_n | input | 1 | Active-low reset |
| rx_d | input | 4 | Receive data nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error from the PHY |
| rd_done | input | 1 | Consumer has finished reading the pending frame |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | ADDR_W | Byte address in the buffer |
| wr_data | output | 8 | Assembled byte |
| rx_size | output | ADDR_W+1 | Stored byte count of the pending frame, 0 when none |
| rx_bad | output | 1 | Pending frame saw a receive error or overflowed |
| rx_odd | output | 1 | Pending frame ended on an odd nibble |

## Verification
Some properties are checked on every cycle:
- No byte is ever written while a result is pending.
- Write strobes never fall on two consecutive cycles.
- The flags are zero whenever the size is zero.
- A pending result holds steady and clears one edge after `rd_done`.

Other behaviour depends on particular frame shapes, so only the bench scenarios show it:
- Correct byte values and byte order.
- Rejection of short preambles, a missing delimiter, and truncation before the delimiter.
- Error capture at a random nibble position.
- Overflow saturation.

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer #(
  parameter int ADDR_W      = 11,
  parameter int PRE_NIBBLES = 15
) (
  input  logic              rx_clk,
  input  logic              rst_n,
  input  logic [3:0]        rx_d,
  input  logic              rx_dv,
  input  logic              rx_er,
  input  logic              rd_done,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W:0]   rx_size,
  output logic              rx_bad,
  output logic              rx_odd
);
  localparam int SIZE_W = ADDR_W + 1;
  localparam int PC_W   = $clog2(PRE_NIBBLES + 1);
  localparam logic [SIZE_W-1:0] CAP = SIZE_W'(1) << ADDR_W;
  localparam logic [PC_W-1:0]   PRE_END = PC_W'(PRE_NIBBLES);
  localparam logic [3:0] PRE_NIB = 4'h5;
  localparam logic [3:0] SFD_NIB = 4'hD;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA, S_SKIP} st_t;

  st_t               st;
  logic [PC_W-1:0]   pcnt;
  logic [SIZE_W-1:0] bcnt;
  logic [3:0]        lo;
  logic              half, er_acc, ovf;
  logic              pend;

  assign pend = (rx_size != '0);

  always_ff @(posedge rx_clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pcnt    <= '0;
      bcnt    <= '0;
      lo      <= '0;
      half    <= 1'b0;
      er_acc  <= 1'b0;
      ovf     <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rx_size <= '0;
      rx_bad  <= 1'b0;
      rx_odd  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (rd_done && pend) begin
        rx_size <= '0;
        rx_bad  <= 1'b0;
        rx_odd  <= 1'b0;
      end
      case (st)
        S_IDLE:
          if (rx_dv) begin
            if (pend || rx_d != PRE_NIB) st <= S_SKIP;
            else begin
              st     <= S_PRE;
              pcnt   <= PC_W'(1);
              er_acc <= rx_er;
            end
          end
        S_PRE:
          if (!rx_dv) st <= S_IDLE;
          else begin
            er_acc <= er_acc | rx_er;
            if (rx_d == PRE_NIB) begin
              if (pcnt != PRE_END) pcnt <= pcnt + 1'b1;
            end else if (rx_d == SFD_NIB && pcnt == PRE_END) begin
              st   <= S_DATA;
              half <= 1'b0;
              bcnt <= '0;
              ovf  <= 1'b0;
            end else st <= S_SKIP;
          end
        S_DATA:
          if (rx_dv) begin
            er_acc <= er_acc | rx_er;
            if (!half) begin
              lo   <= rx_d;
              half <= 1'b1;
            end else begin
              half <= 1'b0;
              if (bcnt == CAP) ovf <= 1'b1;
              else begin
                wr_en   <= 1'b1;
                wr_data <= {rx_d, lo};
                wr_addr <= bcnt[ADDR_W-1:0];
                bcnt    <= bcnt + 1'b1;
              end
            end
          end else begin
            st <= S_IDLE;
            if (bcnt != '0) begin
              rx_size <= bcnt;
              rx_bad  <= er_acc | ovf;
              rx_odd  <= half;
            end
          end
        default:
          if (!rx_dv) st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mii_rx_deframer_chk.sv
module mii_rx_deframer_chk #(
  parameter int ADDR_W = 11
) (
  input logic            rx_clk,
  input logic            rst_n,
  input logic            rd_done,
  input logic            wr_en,
  input logic [ADDR_W:0] rx_size,
  input logic            rx_bad,
  input logic            rx_odd
);
  // R8
  write_idle_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    wr_en |-> rx_size == '0);

  // R3
  write_spacing_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R1
  flags_clear_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_size == '0 |-> (!rx_bad && !rx_odd));

  // R9
  done_clear_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (rd_done && rx_size != '0) |=> rx_size == '0);

  // R11
  pending_hold_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (rx_size != '0 && !rd_done) |=> ($stable(rx_size) && $stable(rx_bad) && $stable(rx_odd)));
endmodule

bind mii_rx_deframer mii_rx_deframer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .rx_clk(rx_clk), .rst_n(rst_n), .rd_done(rd_done), .wr_en(wr_en),
  .rx_size(rx_size), .rx_bad(rx_bad), .rx_odd(rx_odd)
);

// File: tb/sim_mii_rx_deframer.sv
module sim_mii_rx_deframer;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    rx_d = '0;
  logic          rx_dv = 1'b0, rx_er = 1'b0, rd_done = 1'b0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [AW:0]   rx_size;
  logic          rx_bad, rx_odd;

  int nchk = 0, nfail = 0;
  int wcnt = 0, wbad = 0;
  bit pend_m = 0;
  int size_m = 0;
  bit bad_m = 0, odd_m = 0;
  logic [7:0] pay [0:127];

  always #2 clk = ~clk;

  mii_rx_deframer #(.ADDR_W(AW)) u0 (
    .rx_clk(clk), .rst_n(rst_n), .rx_d(rx_d), .rx_dv(rx_dv), .rx_er(rx_er),
    .rd_done(rd_done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_size(rx_size), .rx_bad(rx_bad), .rx_odd(rx_odd)
  );

  always @(negedge clk)
    if (wr_en) begin
      if (int'(wr_addr) != wcnt || wcnt > 127 || wr_data != pay[wcnt & 127]) wbad++;
      wcnt++;
    end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_size(int n);
    return (n > DEPTH) ? DEPTH : n;
  endfunction

  task automatic nib(logic [3:0] d, logic er);
    @(negedge clk);
    rx_dv = 1'b1; rx_d = d; rx_er = er;
  endtask

  task automatic check_state(string req);
    chk({req, " size"}, int'(rx_size), size_m);
    chk({req, " bad"},  int'(rx_bad),  int'(bad_m));
    chk({req, " odd"},  int'(rx_odd),  int'(odd_m));
  endtask

  task automatic frame(int npre, bit sfd, bit cut, int nbytes, bit odd, int er_idx, bit poke, string req);
    int idx = 0;
    bit er_seen = 0;
    bit acc;
    int nw;
    for (int i = 0; i < 128; i++) pay[i] = 8'($urandom);
    wcnt = 0; wbad = 0;
    for (int i = 0; i < npre; i++) begin
      nib(4'h5, idx == er_idx); er_seen |= (idx == er_idx); idx++;
    end
    if (!cut) begin
      nib(sfd ? 4'hD : 4'h3, idx == er_idx); er_seen |= (idx == er_idx); idx++;
      for (int b = 0; b < nbytes; b++) begin
        nib(pay[b & 127][3:0], idx == er_idx); er_seen |= (idx == er_idx); idx++;
        if (poke && b == 0) rd_done = 1'b1;
        nib(pay[b & 127][7:4], idx == er_idx); er_seen |= (idx == er_idx); idx++;
        rd_done = 1'b0;
      end
      if (odd) begin nib(4'hA, idx == er_idx); er_seen |= (idx == er_idx); idx++; end
    end
    @(negedge clk);
    rx_dv = 1'b0; rx_er = 1'b0; rx_d = '0;
    @(negedge clk);
    acc = !pend_m && npre >= 15 && sfd && !cut && nbytes > 0;
    nw = acc ? exp_size(nbytes) : 0;
    if (acc) begin
      pend_m = 1; size_m = nw;
      bad_m = er_seen || nbytes > DEPTH;
      odd_m = odd;
    end
    chk({req, " writes"}, wcnt, nw);
    chk({req, " data"}, wbad, 0);
    check_state(req);
    @(negedge clk);
  endtask

  task automatic clear(string req);
    @(negedge clk); rd_done = 1'b1;
    @(negedge clk); rd_done = 1'b0;
    pend_m = 0; size_m = 0; bad_m = 0; odd_m = 0;
    check_state(req);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        nfail++; nchk++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 wr_en", int'(wr_en), 0);
    check_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 post");
    // R3 R4 basic frame
    frame(15, 1, 0, 8, 0, -1, 0, "R3_R4 basic");
    clear("R9 clear");
    // R9 done with nothing pending: no effect
    @(negedge clk); rd_done = 1'b1; @(negedge clk); rd_done = 1'b0;
    check_state("R9 idle done");
    // R9 done during reception does not disturb it
    frame(15, 1, 0, 5, 0, -1, 1, "R9 mid-frame done");
    clear("R9 clear2");
    // R2 short preamble, missing delimiter, long preamble
    frame(14, 1, 0, 6, 0, -1, 0, "R2 short preamble");
    frame(15, 0, 0, 6, 0, -1, 0, "R2 no delimiter");
    frame(22, 1, 0, 4, 0, -1, 0, "R2 long preamble");
    clear("R9 clear3");
    // R7 truncated before delimiter, zero bytes
    frame(15, 1, 1, 0, 0, -1, 0, "R7 cut");
    frame(15, 1, 0, 0, 1, -1, 0, "R7 no byte");
    // R6 odd ending
    frame(15, 1, 0, 3, 1, -1, 0, "R6 odd");
    // R8 pending ignores new frame
    frame(15, 1, 0, 7, 0, -1, 0, "R8 ignored");
    clear("R9 clear4");
    // R5 error in preamble and in data
    frame(15, 1, 0, 4, 0, 3, 0, "R5 pre err");
    clear("R5 clear");
    frame(15, 1, 0, 4, 0, 20, 0, "R5 data err");
    clear("R5 clear2");
    // R10 overflow
    frame(15, 1, 0, DEPTH + 5, 0, -1, 0, "R10 overflow");
    clear("R10 clear");
    frame(15, 1, 0, DEPTH, 1, -1, 0, "R10 exact fill");
    clear("R10 clear2");
    // random mix
    for (int k = 0; k < 25; k++) begin
      int n = 1 + int'($urandom_range(40));
      bit o = 1'($urandom_range(1));
      int e = ($urandom_range(3) == 0) ? int'($urandom_range(16 + 2 * n)) : -1;
      frame(15 + int'($urandom_range(3)), 1, 0, n, o, e, 0, "R3_R5_R6 random");
      if ($urandom_range(3) != 0) clear("R9 random clear");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule